// File: doc/BRIEF.md
# Overcurrent Alert and Status Controller

This block decides when a power monitor must raise its overcurrent interrupt. It watches two sources of overcurrent evidence. The first is an analog comparator level that arrives asynchronously from the current sense path. The second is a stream of 12-bit current conversion results. Each conversion is checked against a programmable 8-bit threshold. Every alert cause is latched into a status byte, and the block drives an active-low, open-drain alert pin through a pull-low enable.

A register decoder outside the block supplies three write strobes that share one data byte. The enable register selects which causes may latch, and it also carries a self-clearing clear command. The threshold register sets the trip level. The control register holds a software-off request. All three registers and the status byte can be read back.

The digital check has two modes. One trips on a single conversion over the threshold. The other trips only after four conversions in a row are over it. A clear command wipes the latched causes, but any cause that is still present and enabled sets its latch again on the same edge.

Top module: `ovc_alert_ctrl`

## Requirements
- R1: After reset, status reads 0x00, the alert pull-low is 0, the enable readback is 0x04 (only the comparator-latch enable set), the threshold reads 0xFF and the control readback is 0x00.
- R2: A strobe on `en_wr`, `thr_wr` or `ctl_wr` loads `wr_data` at that clock edge. `en_rd` returns enable bits [3:0] and the clear bit in bit 4, with bits 7:5 reading 0. `thr_rd` returns all 8 threshold bits. `ctl_rd` returns the software-off bit in bit 0 and 0 elsewhere.
- R3: With enable bit 0 set, a conversion that exceeds the threshold sets the ADC alert latch (status bit 1) one clock after the status update for that sample. With enable bits 0 and 1 both clear, status bit 1 stays 0.
- R4: A conversion exceeds the threshold only when code bits [11:4] are strictly greater than the threshold. Status bit 0 shows whether the most recent accepted conversion exceeded it.
- R5: Status bits 1, 3 and 5 stay set once latched, until a clear command is given.
- R6: Writing enable bit 4 as 1 clears status bits 1, 3 and 5 on the next edge, and bit 4 reads back as 0 one cycle after the write. On that same edge, a latch whose cause is still present and enabled is set again.
- R7: With enable bit 1 set, the ADC alert latches once four consecutive conversions exceed the threshold. A conversion that does not exceed the threshold restarts the run from zero.
- R8: The comparator input passes through two flip-flops. Status bit 2 follows it two edges later. With enable bit 2 set, status bit 3 latches one edge after that. With enable bit 2 clear, bit 3 stays 0.
- R9: Control bit 0 drives status bit 4 directly. With enable bit 3 set while status bit 4 is 1, status bit 5 latches.
- R10: `alert_pull` is 1 exactly while a latched cause (status bit 1, 3 or 5) is set and its enable is still set: enable bit 0 or 1 for bit 1, enable bit 2 for bit 3, enable bit 3 for bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| thr_wr | input | 1 | Write strobe for the threshold register |
| ctl_wr | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data shared by the three registers |
| cmp_lvl | input | 1 | Asynchronous analog comparator overcurrent level |
| smp_vld | input | 1 | Strobe marking a new current conversion |
| smp_code | input | 12 | Current conversion code |
| status | output | 8 | Status byte (bit 0 last sample over, 1 ADC latch, 2 live comparator, 3 comparator latch, 4 software off, 5 software-off latch) |
| alert_pull | output | 1 | 1 = pull the open-drain alert pin low |
| en_rd | output | 8 | Enable register readback |
| thr_rd | output | 8 | Threshold register readback |
| ctl_rd | output | 8 | Control register readback |

## Verification
A latch that is stuck or dropped shows up as a wrong status bit 1, 3 or 5 and a wrong `alert_pull`. It is visible at the ports one edge after its cause or after a clear, because the latches feed the status byte with no further register. A run counter that is off shows as an alert one sample too early or too late in the four-in-a-row mode, or as an alert after an interrupted run. Those patterns are driven explicitly. An extra or missing synchronizer stage moves the edge of status bit 2 by one cycle, so the bench samples it at the first and the second edge after the input changes.

// File: rtl/ovc_alert_ctrl.sv
module ovc_alert_ctrl #(
  parameter int CODE_W  = 12,
  parameter int THR_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              thr_wr,
  input  logic              ctl_wr,
  input  logic [7:0]        wr_data,
  input  logic              cmp_lvl,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp_code,
  output logic [7:0]        status,
  output logic              alert_pull,
  output logic [7:0]        en_rd,
  output logic [THR_W-1:0]  thr_rd,
  output logic [7:0]        ctl_rd
);
  localparam int LOW_W = CODE_W - THR_W;
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [3:0]       en_q;
  logic             clr_q;
  logic [THR_W-1:0] thr_q;
  logic             sw_q;
  logic             cmp_s1, cmp_s2;
  logic [CNT_W-1:0] run_q;
  logic             last_q;
  logic             adc_lat, cmp_lat, sw_lat;

  // upper bits strictly above threshold <=> whole code above {thr, all ones}
  wire over      = smp_code > {thr_q, {LOW_W{1'b1}}};
  wire run_full  = (run_q == CNT_W'(RUN_LEN));
  wire adc_cause = (en_q[0] & last_q) | (en_q[1] & run_full);
  wire cmp_cause = en_q[2] & cmp_s2;
  wire sw_cause  = en_q[3] & sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 4'b0100;
      clr_q <= 1'b0;
      thr_q <= '1;
      sw_q  <= 1'b0;
    end else begin
      clr_q <= en_wr & wr_data[4];
      if (en_wr)  en_q  <= wr_data[3:0];
      if (thr_wr) thr_q <= wr_data[THR_W-1:0];
      if (ctl_wr) sw_q  <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_s1 <= 1'b0;
      cmp_s2 <= 1'b0;
    end else begin
      cmp_s1 <= cmp_lvl;
      cmp_s2 <= cmp_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (smp_vld) begin
      last_q <= over;
      if (!over)         run_q <= '0;
      else if (!run_full) run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_lat <= 1'b0;
      cmp_lat <= 1'b0;
      sw_lat  <= 1'b0;
    end else begin
      adc_lat <= adc_cause | (adc_lat & ~clr_q);
      cmp_lat <= cmp_cause | (cmp_lat & ~clr_q);
      sw_lat  <= sw_cause  | (sw_lat  & ~clr_q);
    end
  end

  assign status     = {2'b00, sw_lat, sw_q, cmp_lat, cmp_s2, adc_lat, last_q};
  assign alert_pull = (adc_lat & (en_q[0] | en_q[1])) | (cmp_lat & en_q[2]) | (sw_lat & en_q[3]);
  assign en_rd      = {3'b000, clr_q, en_q};
  assign thr_rd     = thr_q;
  assign ctl_rd     = {7'b0, sw_q};
endmodule

module ovc_alert_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr,
  input logic       cmp_lvl,
  input logic [7:0] status,
  input logic       alert_pull,
  input logic [7:0] en_rd
);
  AST_CLR_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rd[4] && !en_wr) |=> !en_rd[4]);                                   // R6
  AST_PIN_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pull |-> (status[1] | status[3] | status[5]));                    // R10
  AST_CMP_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(cmp_lvl, 2));                                // R8
  AST_CMP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !en_rd[4]) |=> status[3]);                                // R5
  AST_SW_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> ($past(en_rd[3]) && $past(status[4])));            // R9
  AST_ADC_LATCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(en_rd[0] | en_rd[1]));                       // R3
endmodule

bind ovc_alert_ctrl ovc_alert_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .cmp_lvl(cmp_lvl),
  .status(status), .alert_pull(alert_pull), .en_rd(en_rd)
);

// File: tb/ovc_alert_ctrl_tb_top.sv
module ovc_alert_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, thr_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic cmp_lvl = 1'b0;
  logic smp_vld = 1'b0;
  logic [11:0] smp_code = 12'h000;
  logic [7:0] status, en_rd, thr_rd, ctl_rd;
  logic alert_pull;

  always #2 clk = ~clk;

  ovc_alert_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .thr_wr(thr_wr), .ctl_wr(ctl_wr),
    .wr_data(wr_data), .cmp_lvl(cmp_lvl), .smp_vld(smp_vld), .smp_code(smp_code),
    .status(status), .alert_pull(alert_pull), .en_rd(en_rd), .thr_rd(thr_rd), .ctl_rd(ctl_rd)
  );

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       al;
    logic [7:0] en;
    logic [7:0] thr;
    logic [7:0] ctl;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] e_en = 8'h04, e_thr = 8'hFF, e_ctl = 8'h00;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    wr_data = d;
    if (sel == 0) begin en_wr = 1'b1; e_en = d & 8'h0F; end
    else if (sel == 1) begin thr_wr = 1'b1; e_thr = d; end
    else begin ctl_wr = 1'b1; e_ctl = d & 8'h01; end
    @(negedge clk);
    en_wr = 1'b0; thr_wr = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic smp(input logic [11:0] c);
    smp_vld = 1'b1; smp_code = c;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic expect_now(input string tag, input logic [7:0] st, input logic al);
    item_t it;
    it.tag = tag; it.st = st; it.al = al; it.en = e_en; it.thr = e_thr; it.ctl = e_ctl;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (status !== it.st || alert_pull !== it.al || en_rd !== it.en ||
            thr_rd !== it.thr || ctl_rd !== it.ctl) begin
          n_fail++;
          $display("FAIL %s: status=%h alert=%b en=%h thr=%h ctl=%h expected status=%h alert=%b en=%h thr=%h ctl=%h",
                   it.tag, status, alert_pull, en_rd, thr_rd, ctl_rd, it.st, it.al, it.en, it.thr, it.ctl);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R1..all requirements unchecked)");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    idle(2);
    rst_n = 1'b1;
    idle(1);
    expect_now("R1 reset state", 8'h00, 1'b0);

    // R2 threshold write, R4 strict compare
    wr(1, 8'h80);
    expect_now("R2 threshold readback", 8'h00, 1'b0);
    smp(12'h805);
    expect_now("R4 equal upper bits not over", 8'h00, 1'b0);
    smp(12'h810);
    expect_now("R4 over sets bit0", 8'h01, 1'b0);
    idle(1);
    expect_now("R3 no latch without enable", 8'h01, 1'b0);

    // R3 single-sample mode
    wr(0, 8'h05);
    idle(1);
    expect_now("R3 single sample latches", 8'h03, 1'b1);
    smp(12'h100);
    idle(1);
    expect_now("R5 ADC latch sticky", 8'h02, 1'b1);
    wr(0, 8'h15);
    idle(1);
    expect_now("R6 clear drops latch", 8'h00, 1'b0);

    // R7 four in a row
    wr(0, 8'h06);
    smp(12'hFF0); smp(12'hFF0); smp(12'hFF0);
    idle(1);
    expect_now("R7 three in a row no alert", 8'h01, 1'b0);
    smp(12'hFF0);
    idle(1);
    expect_now("R7 fourth sample latches", 8'h03, 1'b1);
    wr(0, 8'h16);
    idle(1);
    expect_now("R6 clear re-sets live cause", 8'h03, 1'b1);
    smp(12'h000);
    wr(0, 8'h16);
    idle(1);
    expect_now("R6 clear with cause gone", 8'h00, 1'b0);
    smp(12'hFF0); smp(12'hFF0); smp(12'hFF0); smp(12'h000); smp(12'hFF0);
    idle(1);
    expect_now("R7 broken run restarts", 8'h01, 1'b0);
    smp(12'hFF0); smp(12'hFF0); smp(12'hFF0);
    idle(1);
    expect_now("R7 restarted run latches", 8'h03, 1'b1);

    // R4 top threshold: nothing exceeds 0xFF
    wr(1, 8'hFF);
    smp(12'hFFF);
    wr(0, 8'h15);
    idle(1);
    expect_now("R4 max code vs 0xFF not over", 8'h00, 1'b0);

    // R8 comparator path
    cmp_lvl = 1'b1;
    idle(1);
    expect_now("R8 first stage hidden", 8'h00, 1'b0);
    idle(1);
    expect_now("R8 live bit after two edges", 8'h04, 1'b0);
    idle(1);
    expect_now("R8 comparator latch", 8'h0C, 1'b1);
    cmp_lvl = 1'b0;
    idle(2);
    expect_now("R5 comparator latch sticky", 8'h08, 1'b1);
    wr(0, 8'h15);
    idle(1);
    expect_now("R6 comparator clear", 8'h00, 1'b0);
    wr(0, 8'h01);
    cmp_lvl = 1'b1;
    idle(4);
    expect_now("R8 no latch when disabled", 8'h04, 1'b0);
    cmp_lvl = 1'b0;
    idle(3);

    // R9 software off, R10 pin gating
    wr(2, 8'hFF);
    expect_now("R9 software off status", 8'h10, 1'b0);
    wr(0, 8'h08);
    idle(1);
    expect_now("R9 software off latch", 8'h30, 1'b1);
    wr(0, 8'h00);
    expect_now("R10 disable releases pin", 8'h30, 1'b0);
    wr(0, 8'h08);
    expect_now("R10 re-enable pulls pin", 8'h30, 1'b1);
    wr(2, 8'h00);
    expect_now("R9 latch outlives control bit", 8'h20, 1'b1);
    wr(0, 8'h18);
    idle(1);
    expect_now("R6 software latch clear", 8'h00, 1'b0);

    idle(3);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule